// File: doc/BRIEF.md
# Bus Layer Cycle State Encoder

This block watches one AHB bus layer from the master's side. It turns what the layer did in each bus clock into one compact state code, so that a logic analyzer can record the bus cycle by cycle. Each code says one of the following:

- the layer completed an idle or busy transfer;
- it stalled, and why;
- it saw the first cycle of an error or retry response;
- it completed a sequential beat, tagged with the burst type;
- it completed a nonsequential read or write, tagged with the target slave.

The block captures the address-phase fields (transfer type, burst, direction, slave index) whenever the bus is ready. It combines them with the data-phase ready and response signals and two wait-cause flags from the interconnect. A three-stage register line then delays the resulting code, so every report trails the bus by a fixed three cycles. A parameter selects the full 6-bit code or a narrower 5-bit or 4-bit variant for layers with fewer legal states.

Top module: `bus_state_tracer`

## Requirements
- R1: One code is produced per clock. The code that describes the bus cycle ending at rising edge p is visible on `state_code` from just after edge p+2 until edge p+3, so it trails the bus by three cycles.
- R2: While `rst_n` is low, `state_code` shows the reset code, which is 111111 for the 6-bit variant. The code also stays there for the first edge after release.
- R3: A completing cycle whose captured transfer type was IDLE (`htrans`=00) reports 000000. When the captured type was BUSY (01), it reports 000010.
- R4: A completing SEQ beat (11) reports only the captured burst type. `hburst` values: 001 INCR=000001, 010 WRAP4=011010, 011 INCR4=000011, 100 WRAP8=000100, 101 INCR8=000101, 110 WRAP16=011011, 111 INCR16=000111. SINGLE (000) on a SEQ beat reports 000000.
- R5: A completing NONSEQ transfer (10) reports only direction and slave, and `hburst` has no effect on it. Reads of slaves 0-3 give 001000+s, slaves 4-6 give 011100+(s-4), slaves 8-13 give 111000+(s-8). Writes of slaves 0-6 give 010000+s, slaves 8-13 give 110000+(s-8).
- R6: While `hready` is low and `hresp` is OKAY (00) or SPLIT (11), a wait code replaces the transfer code. The causes rank arbiter first (`wait_arb`, 001110), then interconnect (`wait_link`, 001101). With neither flag set, the wait is a slave wait (001100).
- R7: With `hready` low, `hresp`=ERROR (01) reports 000110 and `hresp`=RETRY (10) reports 111110, above any wait flag. The second response cycle (`hready` high) reports the transfer code.
- R8: A NONSEQ transfer to slave 7 or to any slave index of 14 or above reports 000000.
- R9: With `CODE_W`=4, bits 5 and 4 of every code are 0. The reset code is 001111, retry reports 001100, and any other code with bit 5 or 4 set reports 000000. `CODE_W`=5 applies the same rule to bit 5, with reset code 011111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| htrans | input | 2 | Address-phase transfer type |
| hburst | input | 3 | Address-phase burst type |
| hwrite | input | 1 | Address-phase direction, 1 = write |
| hready | input | 1 | Data-phase ready |
| hresp | input | 2 | Data-phase response |
| tgt_slave | input | SLV_W | Decoded slave index of the address phase |
| wait_arb | input | 1 | Stall caused by arbitration |
| wait_link | input | 1 | Stall caused by interconnect latency |
| state_code | output | CODE_W | Delayed cycle state code |

## Verification
The tests use four kinds of pattern:

- A write burst with one interconnect stall, and a wrapping read burst with stacked stalls. These separate the three wait causes and their ranking, and show that a stall hides the transfer code until the completing cycle.
- A run of back-to-back nonsequential transfers that reach every slave range, plus unassigned indices, with burst values that vary. These show that the slave code depends only on direction and slave, and that unknown slaves fall back to idle.
- A chain of sequential beats with changing burst values. It covers every burst code and the SINGLE case.
- Error and retry responses that arrive while wait flags are set. These show that the response code wins in the first cycle and the transfer code returns in the second.

A 4-bit instance receives the same stimulus, which exposes how codes are substituted when the layer is narrower.

// File: rtl/bst_pkg.sv
package bst_pkg;

   typedef enum logic [1:0] {
      TR_IDLE = 2'b00,
      TR_BUSY = 2'b01,
      TR_NSEQ = 2'b10,
      TR_SEQ  = 2'b11
   } trans_e;

   localparam logic [1:0] RSP_OKAY  = 2'b00;
   localparam logic [1:0] RSP_ERROR = 2'b01;
   localparam logic [1:0] RSP_RETRY = 2'b10;

   localparam logic [5:0] C_IDLE   = 6'b000000;
   localparam logic [5:0] C_BUSY   = 6'b000010;
   localparam logic [5:0] C_ERR1   = 6'b000110;
   localparam logic [5:0] C_RTY1   = 6'b111110;
   localparam logic [5:0] C_WSLV   = 6'b001100;
   localparam logic [5:0] C_WLINK  = 6'b001101;
   localparam logic [5:0] C_WARB   = 6'b001110;

   // Sequential beat code from the burst field
   function automatic logic [5:0] seq_code(input logic [2:0] burst);
      case (burst)
         3'b001:  return 6'b000001;
         3'b010:  return 6'b011010;
         3'b011:  return 6'b000011;
         3'b100:  return 6'b000100;
         3'b101:  return 6'b000101;
         3'b110:  return 6'b011011;
         3'b111:  return 6'b000111;
         default: return C_IDLE;
      endcase
   endfunction

   // Nonsequential code from direction and a 4-bit slave index
   function automatic logic [5:0] nseq_code(input logic wr, input logic [3:0] s);
      if (s == 4'd7 || s > 4'd13) return C_IDLE;
      if (wr) begin
         if (!s[3]) return {3'b010, s[2:0]};
         return {3'b110, s[2:0]};
      end
      if (s < 4'd4) return {3'b001, s[2:0]};
      if (!s[3])    return {4'b0111, 2'(s - 4'd4)};
      return {3'b111, s[2:0]};
   endfunction

endpackage

// File: rtl/bst_capture.sv
module bst_capture #(
   parameter int SLV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hready,
   input  logic [1:0]       htrans,
   input  logic [2:0]       hburst,
   input  logic             hwrite,
   input  logic [SLV_W-1:0] tgt_slave,
   output bst_pkg::trans_e  dp_trans,
   output logic [2:0]       dp_burst,
   output logic             dp_write,
   output logic [SLV_W-1:0] dp_slave
);
   import bst_pkg::*;

   // Address-phase fields move into the data phase only when the bus advances
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dp_trans <= TR_IDLE;
         dp_burst <= '0;
         dp_write <= 1'b0;
         dp_slave <= '0;
      end else if (hready) begin
         dp_trans <= trans_e'(htrans);
         dp_burst <= hburst;
         dp_write <= hwrite;
         dp_slave <= tgt_slave;
      end
   end
endmodule

// File: rtl/bst_classify.sv
module bst_classify #(
   parameter int SLV_W = 4
) (
   input  bst_pkg::trans_e  dp_trans,
   input  logic [2:0]       dp_burst,
   input  logic             dp_write,
   input  logic [SLV_W-1:0] dp_slave,
   input  logic             hready,
   input  logic [1:0]       hresp,
   input  logic             wait_arb,
   input  logic             wait_link,
   output logic [5:0]       code6
);
   import bst_pkg::*;

   logic       slave_fits;
   logic [3:0] slave_lo;

   generate
      if (SLV_W > 4) begin : g_wide_idx
         assign slave_fits = (dp_slave[SLV_W-1:4] == '0);
         assign slave_lo   = dp_slave[3:0];
      end else begin : g_narrow_idx
         assign slave_fits = 1'b1;
         assign slave_lo   = 4'(dp_slave);
      end
   endgenerate

   always_comb begin
      if (!hready) begin
         if (hresp == RSP_ERROR)      code6 = C_ERR1;
         else if (hresp == RSP_RETRY) code6 = C_RTY1;
         else if (wait_arb)           code6 = C_WARB;
         else if (wait_link)          code6 = C_WLINK;
         else                         code6 = C_WSLV;
      end else begin
         case (dp_trans)
            TR_BUSY: code6 = C_BUSY;
            TR_SEQ:  code6 = seq_code(dp_burst);
            TR_NSEQ: code6 = slave_fits ? nseq_code(dp_write, slave_lo) : C_IDLE;
            default: code6 = C_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/bst_delay.sv
module bst_delay #(
   parameter int             W     = 6,
   parameter int             DEPTH = 3,
   parameter logic [W-1:0]   RST_V = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stage[i] <= RST_V;
            else if (i == 0) stage[i] <= d;
            else             stage[i] <= stage[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign q = stage[DEPTH-1];
endmodule

// File: rtl/bus_state_tracer.sv
module bus_state_tracer #(
   parameter int CODE_W = 6,
   parameter int SLV_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        htrans,
   input  logic [2:0]        hburst,
   input  logic              hwrite,
   input  logic              hready,
   input  logic [1:0]        hresp,
   input  logic [SLV_W-1:0]  tgt_slave,
   input  logic              wait_arb,
   input  logic              wait_link,
   output logic [CODE_W-1:0] state_code
);
   import bst_pkg::*;

   localparam int          LAG   = 3;
   localparam logic [5:0]  RST6  = 6'h3F >> (6 - CODE_W);

   generate
      if (CODE_W < 4 || CODE_W > 6) begin : g_bad_code_w
         $error("CODE_W must be 4, 5 or 6");
      end
      if (SLV_W < 4) begin : g_bad_slv_w
         $error("SLV_W must be at least 4");
      end
   endgenerate

   trans_e           dp_trans;
   logic [2:0]       dp_burst;
   logic             dp_write;
   logic [SLV_W-1:0] dp_slave;
   logic [5:0]       code6;
   logic [5:0]       code_n;

   bst_capture #(.SLV_W(SLV_W)) u_capture (
      .clk(clk), .rst_n(rst_n), .hready(hready), .htrans(htrans),
      .hburst(hburst), .hwrite(hwrite), .tgt_slave(tgt_slave),
      .dp_trans(dp_trans), .dp_burst(dp_burst), .dp_write(dp_write),
      .dp_slave(dp_slave)
   );

   bst_classify #(.SLV_W(SLV_W)) u_classify (
      .dp_trans(dp_trans), .dp_burst(dp_burst), .dp_write(dp_write),
      .dp_slave(dp_slave), .hready(hready), .hresp(hresp),
      .wait_arb(wait_arb), .wait_link(wait_link), .code6(code6)
   );

   // Narrow layers substitute codes that do not fit their width
   generate
      if (CODE_W >= 6) begin : g_full
         assign code_n = code6;
      end else begin : g_narrow
         logic fits;
         assign fits   = ((code6 >> CODE_W) == 6'd0);
         assign code_n = fits ? code6 : ((code6 == C_RTY1) ? C_WSLV : C_IDLE);
      end
   endgenerate

   bst_delay #(.W(CODE_W), .DEPTH(LAG), .RST_V(RST6[CODE_W-1:0])) u_delay (
      .clk(clk), .rst_n(rst_n), .d(code_n[CODE_W-1:0]), .q(state_code)
   );

endmodule

// File: rtl/bus_state_tracer_chk.sv
module bus_state_tracer_chk #(
   parameter int CODE_W = 6,
   parameter int SLV_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        htrans,
   input logic              hready,
   input logic [1:0]        hresp,
   input logic [SLV_W-1:0]  tgt_slave,
   input logic              wait_arb,
   input logic              wait_link,
   input logic [CODE_W-1:0] state_code
);
   logic armed;
   logic slave_unknown;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   assign slave_unknown = (tgt_slave == SLV_W'(7)) || (tgt_slave > SLV_W'(13));

   // R6: arbiter stall outranks every other cause
   a_r6_arb_first: assert property (@(posedge clk) disable iff (!rst_n)
      (!hready && hresp == 2'b00 && wait_arb) |=> ##2 state_code == CODE_W'(6'b001110));

   // R6: interconnect stall outranks slave stall
   a_r6_link_over_slave: assert property (@(posedge clk) disable iff (!rst_n)
      (!hready && hresp == 2'b00 && !wait_arb && wait_link)
      |=> ##2 state_code == CODE_W'(6'b001101));

   // R7: error first cycle wins over wait flags
   a_r7_error_first: assert property (@(posedge clk) disable iff (!rst_n)
      (!hready && hresp == 2'b01) |=> ##2 state_code == CODE_W'(6'b000110));

   // R3: completed busy transfer
   a_r3_busy_done: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(hready) && $past(htrans) == 2'b01 && hready)
      |=> ##2 state_code == CODE_W'(6'b000010));

   // R8: unassigned slave reports idle
   a_r8_unknown_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(hready) && $past(htrans) == 2'b10 && $past(slave_unknown) && hready)
      |=> ##2 state_code == '0);
endmodule

bind bus_state_tracer bus_state_tracer_chk #(.CODE_W(CODE_W), .SLV_W(SLV_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .htrans(htrans), .hready(hready), .hresp(hresp),
   .tgt_slave(tgt_slave), .wait_arb(wait_arb), .wait_link(wait_link),
   .state_code(state_code)
);

// File: tb/bus_state_tracer_tb.sv
module bus_state_tracer_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] htrans;
   logic [2:0] hburst;
   logic       hwrite;
   logic       hready;
   logic [1:0] hresp;
   logic [3:0] tgt_slave;
   logic       wait_arb;
   logic       wait_link;
   logic [5:0] code6;
   logic [3:0] code4;

   int n_chk = 0;
   int n_fail = 0;
   int edge_cnt = 0;
   bit done = 0;

   logic [5:0] exp_q [8];
   string      tag_q [8];
   bit         vld_q [8];

   always #4 clk = ~clk;

   bus_state_tracer #(.CODE_W(6), .SLV_W(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .htrans(htrans), .hburst(hburst), .hwrite(hwrite),
      .hready(hready), .hresp(hresp), .tgt_slave(tgt_slave), .wait_arb(wait_arb),
      .wait_link(wait_link), .state_code(code6)
   );

   bus_state_tracer #(.CODE_W(4), .SLV_W(4)) u_dut_n4 (
      .clk(clk), .rst_n(rst_n), .htrans(htrans), .hburst(hburst), .hwrite(hwrite),
      .hready(hready), .hresp(hresp), .tgt_slave(tgt_slave), .wait_arb(wait_arb),
      .wait_link(wait_link), .state_code(code4)
   );

   task automatic check(input string tg, input logic [5:0] act, input logic [5:0] ex);
      n_chk++;
      if (act !== ex) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", tg, act, ex);
      end
   endtask

   // R9 narrowing rule for the 4-bit layer
   function automatic logic [5:0] narrow4(input logic [5:0] c);
      if (c == 6'b111110) return 6'b001100;
      if (c[5:4] != 2'b00) return 6'b000000;
      return c;
   endfunction

   always @(posedge clk) edge_cnt++;

   // R1: entry stored for edge p is checked after edge p+2
   always @(negedge clk) begin
      int idx;
      idx = (edge_cnt - 2) & 7;
      if (edge_cnt >= 2 && vld_q[idx]) begin
         check({tag_q[idx], " R1"}, code6, exp_q[idx]);
         check({tag_q[idx], " R9"}, {2'b00, code4}, narrow4(exp_q[idx]));
         vld_q[idx] = 1'b0;
      end
   end

   task automatic step(input logic [1:0] tr, input logic [2:0] bu, input logic wr,
                       input logic [3:0] sl, input logic rdy, input logic [1:0] rsp,
                       input logic arb, input logic lnk, input logic [5:0] ex,
                       input string tg);
      int idx;
      @(negedge clk);
      htrans = tr; hburst = bu; hwrite = wr; tgt_slave = sl;
      hready = rdy; hresp = rsp; wait_arb = arb; wait_link = lnk;
      idx = (edge_cnt + 1) & 7;
      exp_q[idx] = ex;
      tag_q[idx] = tg;
      vld_q[idx] = (tg != "");
   endtask

   task automatic flush();
      for (int i = 0; i < 4; i++) step(2'b00, 3'b000, 0, 4'd0, 1, 2'b00, 0, 0, 6'd0, "");
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b0;
      htrans = 2'b00; hburst = 3'b000; hwrite = 0; tgt_slave = 0;
      hready = 1; hresp = 2'b00; wait_arb = 0; wait_link = 0;
      #1;
      check("R2 reset code", code6, 6'b111111);
      check("R9 narrow reset code", {2'b00, code4}, 6'b001111);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R2 held after release", code6, 6'b111111);
   endtask

   task automatic t_idle_busy();
      step(2'b01, 3'b000, 0, 4'd0, 1, 2'b00, 0, 0, 6'b000000, "R3 idle");
      step(2'b00, 3'b000, 0, 4'd0, 1, 2'b00, 0, 0, 6'b000010, "R3 busy");
      step(2'b00, 3'b000, 0, 4'd0, 1, 2'b00, 0, 0, 6'b000000, "R3 idle after busy");
      flush();
   endtask

   task automatic t_write_burst();
      step(2'b10, 3'b011, 1, 4'd1, 1, 2'b00, 0, 0, 6'b000000, "R3 idle before");
      step(2'b11, 3'b011, 1, 4'd1, 0, 2'b00, 0, 1, 6'b001101, "R6 link wait");
      step(2'b11, 3'b011, 1, 4'd1, 1, 2'b00, 0, 0, 6'b010001, "R5 write s1");
      step(2'b11, 3'b011, 1, 4'd1, 1, 2'b00, 0, 0, 6'b000011, "R4 incr4");
      step(2'b00, 3'b000, 0, 4'd0, 1, 2'b00, 0, 0, 6'b000011, "R4 incr4");
      step(2'b00, 3'b000, 0, 4'd0, 1, 2'b00, 0, 0, 6'b000000, "R3 idle after");
      flush();
   endtask

   task automatic t_read_wrap();
      step(2'b10, 3'b010, 0, 4'd2, 1, 2'b00, 0, 0, 6'b000000, "R3 idle before");
      step(2'b11, 3'b010, 0, 4'd2, 0, 2'b00, 0, 1, 6'b001101, "R6 link wait");
      step(2'b11, 3'b010, 0, 4'd2, 0, 2'b00, 1, 1, 6'b001110, "R6 arb over link");
      step(2'b11, 3'b010, 0, 4'd2, 1, 2'b00, 0, 0, 6'b001010, "R5 read s2");
      step(2'b00, 3'b000, 0, 4'd0, 0, 2'b00, 0, 0, 6'b001100, "R6 slave wait");
      step(2'b00, 3'b000, 0, 4'd0, 0, 2'b11, 0, 1, 6'b001101, "R6 link on split");
      step(2'b00, 3'b000, 0, 4'd0, 1, 2'b00, 0, 0, 6'b011010, "R4 wrap4");
      step(2'b00, 3'b000, 0, 4'd0, 1, 2'b00, 0, 0, 6'b000000, "R3 idle after");
      flush();
   endtask

   task automatic t_slave_ranges();
      step(2'b10, 3'b111, 0, 4'd5,  1, 2'b00, 0, 0, 6'b000000, "R3 idle before");
      step(2'b10, 3'b011, 0, 4'd9,  1, 2'b00, 0, 0, 6'b011101, "R5 read s5 burst ignored");
      step(2'b10, 3'b000, 1, 4'd12, 1, 2'b00, 0, 0, 6'b111001, "R5 read s9");
      step(2'b10, 3'b101, 0, 4'd7,  1, 2'b00, 0, 0, 6'b110100, "R5 write s12");
      step(2'b10, 3'b001, 1, 4'd15, 1, 2'b00, 0, 0, 6'b000000, "R8 read s7");
      step(2'b10, 3'b110, 1, 4'd6,  1, 2'b00, 0, 0, 6'b000000, "R8 write s15");
      step(2'b10, 3'b000, 0, 4'd13, 1, 2'b00, 0, 0, 6'b010110, "R5 write s6");
      step(2'b00, 3'b000, 0, 4'd0,  1, 2'b00, 0, 0, 6'b111101, "R5 read s13");
      flush();
   endtask

   task automatic t_seq_codes();
      step(2'b10, 3'b001, 0, 4'd0, 1, 2'b00, 0, 0, 6'b000000, "R3 idle before");
      step(2'b11, 3'b001, 0, 4'd0, 1, 2'b00, 0, 0, 6'b001000, "R5 read s0");
      step(2'b11, 3'b100, 0, 4'd0, 1, 2'b00, 0, 0, 6'b000001, "R4 incr");
      step(2'b11, 3'b101, 0, 4'd0, 1, 2'b00, 0, 0, 6'b000100, "R4 wrap8");
      step(2'b11, 3'b111, 0, 4'd0, 1, 2'b00, 0, 0, 6'b000101, "R4 incr8");
      step(2'b11, 3'b110, 0, 4'd0, 1, 2'b00, 0, 0, 6'b000111, "R4 incr16");
      step(2'b11, 3'b000, 0, 4'd0, 1, 2'b00, 0, 0, 6'b011011, "R4 wrap16");
      step(2'b00, 3'b000, 0, 4'd0, 1, 2'b00, 0, 0, 6'b000000, "R4 single seq");
      flush();
   endtask

   task automatic t_responses();
      step(2'b10, 3'b000, 1, 4'd0, 1, 2'b00, 0, 0, 6'b000000, "R3 idle before");
      step(2'b00, 3'b000, 0, 4'd0, 0, 2'b01, 1, 1, 6'b000110, "R7 error first");
      step(2'b00, 3'b000, 0, 4'd0, 1, 2'b01, 0, 0, 6'b010000, "R7 error second");
      step(2'b10, 3'b000, 0, 4'd3, 1, 2'b00, 0, 0, 6'b000000, "R3 idle between");
      step(2'b00, 3'b000, 0, 4'd0, 0, 2'b10, 1, 0, 6'b111110, "R7 retry first");
      step(2'b00, 3'b000, 0, 4'd0, 1, 2'b10, 0, 0, 6'b001011, "R7 retry second");
      step(2'b00, 3'b000, 0, 4'd0, 1, 2'b00, 0, 0, 6'b000000, "R3 idle after");
      flush();
   endtask

   initial begin
      for (int i = 0; i < 8; i++) vld_q[i] = 1'b0;
      t_reset();
      t_idle_busy();
      t_write_burst();
      t_read_wrap();
      t_slave_ranges();
      t_seq_codes();
      t_responses();
      t_reset();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule